// File: doc/BRIEF.md
# Out-of-order write address resolver

This block sits behind the packet parser of a receiver that accepts out-of-order data packets of one transfer per queue. For every data packet it produces the memory address where that packet's payload belongs, so the payload can be stored without being reordered first. The address is the transfer's start address plus the PSN offset of the packet, scaled by the fixed full-packet payload size. Every packet except the last one of a transfer carries exactly that payload size.

On the write-responder side the start address is not known in advance. The sender therefore attaches an explicit address to its early packets. The first such packet lets the block recover the start address and cache it per queue, and a per-queue "learned" flag is raised. Acknowledgments report this flag, which tells the sender to stop attaching the address. Later packets are then placed from PSN arithmetic alone.

On the read-requester side, local logic arms a queue with both the start PSN and the start address, so no response packet has to carry an address. The last packet of a transfer increments the queue's message sequence number by one. It also clears the learned flag and sets the next transfer's start PSN to the PSN after it.

Top module: `ooo_addr_resolver`

## Requirements
- R1: Every cycle with pkt_valid high produces exactly one result on the next clock edge: either wr_valid or wr_err, with wr_qid echoing the queue and wr_last echoing bit 1 of pkt_kind. A cycle without a packet produces neither.
- R2: pkt_kind bit 0 set means the packet carries an address. If such a packet reaches a queue without a learned start, wr_addr is the carried address. The queue caches start = carried address − (PSN offset << PMTU_LOG2), and its learned bit goes high from the next cycle.
- R3: For a packet without an address (kind 00 or 10) on a learned queue, wr_addr = cached start + (PSN offset << PMTU_LOG2), modulo 2^AW.
- R4: A packet without an address on a queue with no learned start raises wr_err without wr_valid. The queue's start PSN, start address, message number and learned bit stay unchanged.
- R5: The PSN offset is (packet PSN − start PSN) modulo 2^24, so a transfer whose PSNs wrap past 0xFFFFFF is placed correctly.
- R6: A successful last packet (pkt_kind bit 1 set, kind 10 or 11) reports wr_msn equal to the queue's previous message number plus 1 and stores that value. It also clears the learned bit and sets the start PSN to the packet PSN + 1 modulo 2^24.
- R7: arm_valid loads the start PSN of queue arm_qid. With arm_known high it also caches arm_addr and sets the learned bit. With arm_known low it clears the learned bit. When an arm and a packet target the same queue in the same cycle, the arm decides the stored start fields.
- R8: On a learned queue, an address carried by a packet is ignored. The packet is placed from the cached start, and the cache is not changed.
- R9: After reset, every learned bit, message number and start PSN is zero, and wr_valid and wr_err are low.
- R10: Queues are independent: packets and arms on one queue leave every other queue's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Load start context for a queue |
| arm_qid | input | QW | Queue being armed |
| arm_psn | input | PSNW | Start PSN of the next transfer |
| arm_addr | input | AW | Start address (used when arm_known is high) |
| arm_known | input | 1 | Start address supplied locally |
| pkt_valid | input | 1 | Parsed data packet present |
| pkt_qid | input | QW | Queue of the packet |
| pkt_psn | input | PSNW | Packet sequence number |
| pkt_kind | input | 2 | Bit 0: carries address; bit 1: last of transfer |
| pkt_addr | input | AW | Carried write address |
| wr_valid | output | 1 | Write address valid strobe |
| wr_err | output | 1 | Packet could not be placed |
| wr_qid | output | QW | Queue of the result |
| wr_addr | output | AW | Payload write address |
| wr_last | output | 1 | Result belongs to a last packet |
| wr_msn | output | MSNW | Message number of the queue after this packet |
| learned | output | NQ | Per-queue start-address-learned flags |

## Verification
The address path is tried with packets that arrive in scrambled PSN order after one address-carrying packet. This separates placement from the cache from a pass-through of the carried field. A deliberately wrong carried address on a learned queue shows whether the cache or the packet field wins. Address-less packets sent before learning and right after a last packet expose a flag that is not held or not cleared. A transfer armed just below the 24-bit PSN limit distinguishes modular from plain subtraction. Interleaved traffic on two queues catches state leaking between queues.

// File: rtl/ooo_addr_resolver.sv
module ooo_addr_resolver #(
  parameter int NQ        = 8,
  parameter int AW        = 48,
  parameter int PSNW      = 24,
  parameter int MSNW      = 24,
  parameter int PMTU_LOG2 = 12,
  localparam int QW       = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_valid,
  input  logic [QW-1:0]   arm_qid,
  input  logic [PSNW-1:0] arm_psn,
  input  logic [AW-1:0]   arm_addr,
  input  logic            arm_known,
  input  logic            pkt_valid,
  input  logic [QW-1:0]   pkt_qid,
  input  logic [PSNW-1:0] pkt_psn,
  input  logic [1:0]      pkt_kind,
  input  logic [AW-1:0]   pkt_addr,
  output logic            wr_valid,
  output logic            wr_err,
  output logic [QW-1:0]   wr_qid,
  output logic [AW-1:0]   wr_addr,
  output logic            wr_last,
  output logic [MSNW-1:0] wr_msn,
  output logic [NQ-1:0]   learned
);

  logic [PSNW-1:0] spsn_q  [NQ];
  logic [AW-1:0]   start_q [NQ];
  logic [MSNW-1:0] msn_q   [NQ];

  logic            has_addr, is_last, known_now, ok;
  logic [PSNW-1:0] diff;
  logic [AW-1:0]   off, calc_addr, learn_addr;
  logic [MSNW-1:0] msn_now;

  assign has_addr   = pkt_kind[0];
  assign is_last    = pkt_kind[1];
  assign known_now  = learned[pkt_qid];
  assign ok         = known_now | has_addr;
  assign diff       = pkt_psn - spsn_q[pkt_qid];
  assign off        = AW'(diff) << PMTU_LOG2;
  assign calc_addr  = start_q[pkt_qid] + off;
  assign learn_addr = pkt_addr - off;
  assign msn_now    = msn_q[pkt_qid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_err   <= 1'b0;
      wr_qid   <= '0;
      wr_addr  <= '0;
      wr_last  <= 1'b0;
      wr_msn   <= '0;
      learned  <= '0;
      for (int i = 0; i < NQ; i++) begin
        spsn_q[i]  <= '0;
        start_q[i] <= '0;
        msn_q[i]   <= '0;
      end
    end else begin
      wr_valid <= pkt_valid & ok;
      wr_err   <= pkt_valid & ~ok;
      if (pkt_valid) begin
        wr_qid  <= pkt_qid;
        wr_last <= is_last;
        wr_addr <= known_now ? calc_addr : pkt_addr;
        wr_msn  <= (ok && is_last) ? msn_now + 1'b1 : msn_now;
        if (ok) begin
          if (is_last) begin
            learned[pkt_qid] <= 1'b0;
            spsn_q[pkt_qid]  <= pkt_psn + 1'b1;
            msn_q[pkt_qid]   <= msn_now + 1'b1;
          end else if (!known_now) begin
            learned[pkt_qid] <= 1'b1;
            start_q[pkt_qid] <= learn_addr;
          end
        end
      end
      if (arm_valid) begin
        spsn_q[arm_qid]  <= arm_psn;
        learned[arm_qid] <= arm_known;
        if (arm_known) start_q[arm_qid] <= arm_addr;
      end
    end
  end

endmodule

// File: rtl/ooo_addr_resolver_chk.sv
module ooo_addr_resolver_chk #(
  parameter int NQ = 8,
  parameter int QW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm_valid,
  input logic [QW-1:0] arm_qid,
  input logic          pkt_valid,
  input logic [QW-1:0] pkt_qid,
  input logic [1:0]    pkt_kind,
  input logic          wr_valid,
  input logic          wr_err,
  input logic [NQ-1:0] learned
);

  logic same_q;
  assign same_q = arm_valid && (arm_qid == pkt_qid);

  a_r1_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> (wr_valid ^ wr_err));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> (!wr_valid && !wr_err));

  a_r4_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_kind[0] && !learned[pkt_qid]) |=> (wr_err && !wr_valid));

  a_r2_learn: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'b01 && !same_q) |=> learned[$past(pkt_qid)]);

  a_r6_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind[1] && !same_q) |=> !learned[$past(pkt_qid)]);

endmodule

bind ooo_addr_resolver ooo_addr_resolver_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_qid(arm_qid),
  .pkt_valid(pkt_valid), .pkt_qid(pkt_qid), .pkt_kind(pkt_kind),
  .wr_valid(wr_valid), .wr_err(wr_err), .learned(learned)
);

// File: tb/ooo_addr_resolver_bench.sv
module ooo_addr_resolver_bench;
  localparam int NQ = 8, AW = 48, PSNW = 24, MSNW = 24, SH = 12, QW = 3;

  logic clk = 0, rst_n = 0;
  logic arm_valid = 0, arm_known = 0, pkt_valid = 0;
  logic [QW-1:0] arm_qid = 0, pkt_qid = 0;
  logic [PSNW-1:0] arm_psn = 0, pkt_psn = 0;
  logic [AW-1:0] arm_addr = 0, pkt_addr = 0;
  logic [1:0] pkt_kind = 0;
  logic wr_valid, wr_err, wr_last;
  logic [QW-1:0] wr_qid;
  logic [AW-1:0] wr_addr;
  logic [MSNW-1:0] wr_msn;
  logic [NQ-1:0] learned;

  ooo_addr_resolver u_ooo_addr_resolver (.*);

  always #5 clk = ~clk;

  typedef struct { logic err; logic [QW-1:0] q; logic [AW-1:0] a;
                   logic last; logic [MSNW-1:0] msn; string req; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0;
  bit done = 0;

  logic            m_known [NQ];
  logic [PSNW-1:0] m_spsn  [NQ];
  logic [AW-1:0]   m_start [NQ];
  logic [MSNW-1:0] m_msn   [NQ];

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic arm(int q, logic [PSNW-1:0] psn, logic known, logic [AW-1:0] addr);
    arm_valid = 1; arm_qid = QW'(q); arm_psn = psn; arm_known = known; arm_addr = addr;
    m_spsn[q] = psn; m_known[q] = known;
    if (known) m_start[q] = addr;
    @(negedge clk);
    arm_valid = 0;
  endtask

  task automatic send(int q, logic [1:0] kind, logic [PSNW-1:0] psn,
                      logic [AW-1:0] addr, string req);
    exp_t e;
    logic [PSNW-1:0] d;
    logic [AW-1:0] off;
    d = psn - m_spsn[q];
    off = AW'(d) << SH;
    e.q = QW'(q); e.last = kind[1]; e.req = req;
    e.err = !(m_known[q] || kind[0]);
    e.a = m_known[q] ? m_start[q] + off : addr;
    e.msn = m_msn[q];
    if (!e.err) begin
      if (kind[1]) begin
        m_msn[q] = m_msn[q] + 1; e.msn = m_msn[q];
        m_known[q] = 0; m_spsn[q] = psn + 1;
      end else if (!m_known[q]) begin
        m_known[q] = 1; m_start[q] = addr - off;
      end
    end
    exp_q.push_back(e);
    pkt_valid = 1; pkt_qid = QW'(q); pkt_kind = kind; pkt_psn = psn; pkt_addr = addr;
    @(negedge clk);
    pkt_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (wr_valid || wr_err)) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.req, " err"}, 64'(wr_err), 64'(e.err));
        check("R1 strobe", 64'(wr_valid), 64'(!e.err));
        check("R1 qid", 64'(wr_qid), 64'(e.q));
        if (!e.err) begin
          check({e.req, " addr"}, 64'(wr_addr), 64'(e.a));
          check("R1 last", 64'(wr_last), 64'(e.last));
          check({e.req, " msn"}, 64'(wr_msn), 64'(e.msn));
        end
      end
    end
  end

  task automatic idle_check_learned(string req);
    @(negedge clk);
    for (int i = 0; i < NQ; i++) check(req, 64'(learned[i]), 64'(m_known[i]));
  endtask

  initial begin
    for (int i = 0; i < NQ; i++) begin
      m_known[i] = 0; m_spsn[i] = 0; m_start[i] = 0; m_msn[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R9 learned", 64'(learned), 0);
    check("R9 valid", 64'(wr_valid), 0);
    check("R9 err", 64'(wr_err), 0);
    rst_n = 1;
    @(negedge clk);
    // R9: zero start PSN and message number after reset, seen through placement
    send(2, 2'b01, 24'd3, 48'h0000_0020_3000, "R9 r2_");
    send(2, 2'b10, 24'd4, 0, "R9 r6_");
    // R7 / R4: armed without address, address-less packet is refused
    arm(0, 24'd100, 0, 0);
    send(0, 2'b00, 24'd101, 0, "R4");
    idle_check_learned("R4 learned held low");
    // R2: learn from a carried address arriving out of order
    send(0, 2'b01, 24'd104, 48'h0010_0000_4000, "R2");
    idle_check_learned("R2 learned set");
    // R3: scrambled address-less packets
    send(0, 2'b00, 24'd102, 0, "R3");
    send(0, 2'b00, 24'd100, 0, "R3");
    send(0, 2'b00, 24'd107, 0, "R3");
    // R8: bogus carried address ignored
    send(0, 2'b01, 24'd103, 48'h0BAD_0000_0000, "R8");
    send(0, 2'b00, 24'd105, 0, "R8 cache kept");
    // R6: last packet bumps MSN, clears flag, advances start PSN
    send(0, 2'b10, 24'd108, 0, "R6");
    idle_check_learned("R6 cleared");
    send(0, 2'b00, 24'd110, 0, "R6 r4_ after last");
    send(0, 2'b01, 24'd111, 48'h0020_0000_2000, "R6 next start");
    send(0, 2'b00, 24'd109, 0, "R6 next start");
    send(0, 2'b11, 24'd112, 48'h0123, "R6 last with addr");
    // R5: wrap across the 24-bit PSN limit, R7 locally known start
    arm(3, 24'hFFFFFE, 1, 48'h0000_4000_0000);
    idle_check_learned("R7 armed known");
    send(3, 2'b00, 24'h000001, 0, "R5");
    send(3, 2'b00, 24'hFFFFFF, 0, "R5");
    send(3, 2'b10, 24'h000002, 0, "R5 r6_");
    check("R5 next start", 64'(m_spsn[3]), 64'(24'h3));
    send(3, 2'b01, 24'h000004, 48'h0000_5000_1000, "R5 r2_ after wrap");
    // R10: interleaved queues
    arm(5, 24'd500, 0, 0);
    send(5, 2'b01, 24'd502, 48'h0000_7000_2000, "R10");
    send(3, 2'b00, 24'h000003, 0, "R10");
    send(5, 2'b00, 24'd501, 0, "R10");
    send(3, 2'b10, 24'h000005, 0, "R10");
    send(5, 2'b10, 24'd503, 0, "R10");
    idle_check_learned("R10 flags");
    // R7: arm without address clears learned
    arm(1, 24'd7, 1, 48'h100);
    arm(1, 24'd9, 0, 0);
    idle_check_learned("R7 cleared by arm");
    send(1, 2'b00, 24'd9, 0, "R7 r4_");
    repeat (3) @(negedge clk);
    check("R1 all results seen", 64'(exp_q.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule